// File: doc/BRIEF.md
# Periodic Interrupt and Timer Flag Unit

This block pairs a free-running up-counter with a fixed-rate periodic tick generator and collects their events, together with two externally supplied event strobes, into a four-bit sticky flag register. Each flag has an enable bit in the same bit position of a mask register. The single interrupt request output is raised while any flag is set and enabled. Software sees everything through a byte-wide register bus. It can either poll the flags with all enables off, or take the interrupt and clear the flags that it has serviced by writing ones to them.

The periodic tick comes from a divider that runs from reset and never stops. A two-bit rate field picks which power-of-two tap of that divider fires the tick. Changing the rate therefore never restarts the divider, and ticks always fall on multiples of the chosen period counted from reset. The widths of the counter and the shortest tick period are parameters.

Top module: `periodic_flag_timer`

## Requirements
- R1: After reset, the flag register (address 0), the mask register (address 1), the rate register (address 2) and the counter read 0, and `irq` is low.
- R2: The counter advances by one every clock from 0 after reset and wraps from all ones to 0. Address 3 returns bits 15:8 and address 4 returns bits 7:0 of its zero-extended value.
- R3: Flag bit 7 (counter wrap) becomes 1 in the cycle in which the counter goes from all ones to 0.
- R4: Flag bit 6 (periodic tick) becomes 1 every 2^(MIN_SHIFT + rate) clocks, where rate is bits 1:0 of address 2. Each tick lands on an exact multiple of that period counted from reset, because a rate change does not restart the divider.
- R5: A one-cycle pulse on `pa_ovf_stb` sets flag bit 5, and a one-cycle pulse on `pa_edge_stb` sets flag bit 4.
- R6: Writing address 0 clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R7: When a set event and a clearing write reach the same flag in the same cycle, the flag ends up at 1.
- R8: Mask bits 7:4 store the written data. Bits 3:0 of the flag and mask registers and bits 7:2 of the rate register always read 0.
- R9: `irq` equals the OR, over bits 7:4, of flag AND mask. Flags still set and read back while their mask bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pa_ovf_stb | input | 1 | External overflow event strobe |
| pa_edge_stb | input | 1 | External edge event strobe |
| irq | output | 1 | Interrupt request |

## Verification
The bench runs a reduced configuration (8-bit counter, shortest tick period of 8 clocks) so that every rate and the counter wrap can be observed many times. All four rates are swept back to back without a reset, which tells a divider that keeps running apart from one that restarts when the rate is written. Every one of the 16 mask nibbles is tried against each combination of the external event flags, and that exposes a wrong bit pairing in the interrupt OR. Clearing writes are tried with and without a simultaneous set event, and with zero data, to separate the set-wins rule from plain write-one-to-clear and from writes that have no effect.

// File: rtl/pft_pkg.sv
package pft_pkg;

    localparam int BUS_W = 8;
    localparam int ADDR_W = 3;
    localparam int NUM_FLAGS = 4;
    localparam int NUM_RATES = 4;

    // register addresses
    localparam logic [ADDR_W-1:0] A_FLAGS = 3'd0;
    localparam logic [ADDR_W-1:0] A_MASK  = 3'd1;
    localparam logic [ADDR_W-1:0] A_RATE  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT_H = 3'd3;
    localparam logic [ADDR_W-1:0] A_CNT_L = 3'd4;

    // event bundle, most significant field maps to register bit 7
    typedef struct packed {
        logic wrap;
        logic tick;
        logic ext_ovf;
        logic ext_edge;
    } evt_t;

    typedef logic [NUM_FLAGS-1:0] nib_t;

    function automatic nib_t evt_to_nib(evt_t e);
        return {e.wrap, e.tick, e.ext_ovf, e.ext_edge};
    endfunction

    function automatic logic [BUS_W-1:0] nib_to_byte(nib_t n);
        return {n, {(BUS_W-NUM_FLAGS){1'b0}}};
    endfunction

endpackage

// File: rtl/pft_free_counter.sv
module pft_free_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] count,
    output logic             wrap_evt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + 1'b1;
    end

    // asserted in the cycle before the counter returns to zero
    assign wrap_evt = (count == CNT_MAX);

    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> count == $past(count) + 1'b1);

    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        wrap_evt |=> count == '0);

endmodule

// File: rtl/pft_rti_div.sv
module pft_rti_div #(
    parameter int MIN_SHIFT = 13
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rate,
    output logic       tick_evt
);
    localparam int DIV_W = MIN_SHIFT + pft_pkg::NUM_RATES - 1;

    logic [DIV_W-1:0] div_q;
    logic [pft_pkg::NUM_RATES-1:0] tap_hit;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    // one tap per rate: the low (MIN_SHIFT + r) bits are all ones
    for (genvar r = 0; r < pft_pkg::NUM_RATES; r++) begin : g_tap
        assign tap_hit[r] = &div_q[MIN_SHIFT+r-1:0];
    end

    assign tick_evt = tap_hit[rate];

    a_r4_tick_isolated: assert property (@(posedge clk) disable iff (rst)
        tick_evt |=> !tick_evt);

    a_r4_div_free_running: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> div_q == $past(div_q) + 1'b1);

endmodule

// File: rtl/pft_flag_bank.sv
module pft_flag_bank
    import pft_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  nib_t set_evt,
    input  nib_t clr_req,
    input  logic mask_we,
    input  nib_t mask_wdata,
    output nib_t flags,
    output nib_t mask,
    output logic irq
);
    nib_t flags_q;
    nib_t mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            mask_q  <= '0;
        end else begin
            // set has priority over a simultaneous clear
            flags_q <= (flags_q & ~clr_req) | set_evt;
            if (mask_we) mask_q <= mask_wdata;
        end
    end

    assign flags = flags_q;
    assign mask  = mask_q;
    assign irq   = |(flags_q & mask_q);

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_chk
        a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
            set_evt[i] |=> flags_q[i]);
        a_r6_clear_one: assert property (@(posedge clk) disable iff (rst)
            (clr_req[i] && !set_evt[i]) |=> !flags_q[i]);
        a_r6_hold_zero: assert property (@(posedge clk) disable iff (rst)
            (!clr_req[i] && !set_evt[i]) |=> $stable(flags_q[i]));
    end

    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq);

endmodule

// File: rtl/periodic_flag_timer.sv
module periodic_flag_timer
    import pft_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int MIN_SHIFT = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic             bus_wr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             pa_ovf_stb,
    input  logic             pa_edge_stb,
    output logic             irq
);
    localparam int EXT_W = 2 * BUS_W;

    logic [CNT_W-1:0] count;
    logic [EXT_W-1:0] count_ext;
    logic             wrap_evt;
    logic             tick_evt;
    logic [1:0]       rate_q;
    evt_t             events;
    nib_t             clr_req;
    nib_t             flags;
    nib_t             mask;
    logic             unused_wbits;

    pft_free_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .count    (count),
        .wrap_evt (wrap_evt)
    );

    pft_rti_div #(.MIN_SHIFT(MIN_SHIFT)) u_div (
        .clk      (clk),
        .rst      (rst),
        .rate     (rate_q),
        .tick_evt (tick_evt)
    );

    always_ff @(posedge clk) begin
        if (rst)                             rate_q <= '0;
        else if (bus_wr && bus_addr == A_RATE) rate_q <= bus_wdata[1:0];
    end

    always_comb begin
        events.wrap     = wrap_evt;
        events.tick     = tick_evt;
        events.ext_ovf  = pa_ovf_stb;
        events.ext_edge = pa_edge_stb;
    end

    assign clr_req = (bus_wr && bus_addr == A_FLAGS) ? bus_wdata[BUS_W-1 -: NUM_FLAGS] : '0;

    pft_flag_bank u_flags (
        .clk        (clk),
        .rst        (rst),
        .set_evt    (evt_to_nib(events)),
        .clr_req    (clr_req),
        .mask_we    (bus_wr && bus_addr == A_MASK),
        .mask_wdata (bus_wdata[BUS_W-1 -: NUM_FLAGS]),
        .flags      (flags),
        .mask       (mask),
        .irq        (irq)
    );

    always_comb begin
        count_ext = '0;
        count_ext[CNT_W-1:0] = count;
    end

    always_comb begin
        unique case (bus_addr)
            A_FLAGS: bus_rdata = nib_to_byte(flags);
            A_MASK:  bus_rdata = nib_to_byte(mask);
            A_RATE:  bus_rdata = {{(BUS_W-2){1'b0}}, rate_q};
            A_CNT_H: bus_rdata = count_ext[EXT_W-1:BUS_W];
            A_CNT_L: bus_rdata = count_ext[BUS_W-1:0];
            default: bus_rdata = '0;
        endcase
    end

    assign unused_wbits = ^bus_wdata[3:2];

    a_r8_low_nibble_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_FLAGS || bus_addr == A_MASK) |-> bus_rdata[3:0] == 4'h0);

    a_r3_wrap_sets_flag: assert property (@(posedge clk) disable iff (rst)
        wrap_evt |=> flags[3]);

    a_r4_tick_sets_flag: assert property (@(posedge clk) disable iff (rst)
        tick_evt |=> flags[2]);

endmodule

// File: tb/periodic_flag_timer_bench.sv
module periodic_flag_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 8;
    localparam int MIN_SHIFT = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       pa_ovf_stb = 1'b0;
    logic       pa_edge_stb = 1'b0;
    logic       irq;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    periodic_flag_timer #(.CNT_W(CNT_W), .MIN_SHIFT(MIN_SHIFT)) u_periodic_flag_timer (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pa_ovf_stb(pa_ovf_stb), .pa_edge_stb(pa_edge_stb), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // edges since reset release, which is what the counter must show
    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] rd2;
        int hit;
        int period;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset values
        for (int a = 0; a < 5; a++) begin
            bus_read(a[2:0], rd);
            check(rd == 8'h00, "R1", rd, 0);
        end
        check(irq == 1'b0, "R1 irq", irq, 0);
        rst = 1'b0;

        // R2/R3 counter and wrap flag
        while (cyc < 255) @(negedge clk);
        bus_read(3'd4, rd);
        check(rd == 8'd255, "R2 low", rd, 255);
        bus_read(3'd3, rd);
        check(rd == 8'd0, "R2 high", rd, 0);
        bus_read(3'd0, rd);
        check(rd[7] == 1'b0, "R3 before wrap", rd[7], 0);
        @(negedge clk);
        bus_read(3'd0, rd);
        check(rd[7] == 1'b1, "R3 after wrap", rd[7], 1);
        bus_read(3'd4, rd);
        check(rd == 8'd0, "R2 wrapped", rd, 0);
        repeat (37) @(negedge clk);
        bus_read(3'd4, rd);
        check(rd == 8'(cyc), "R2 count", rd, cyc % 256);

        // R6 zero write keeps flags, one write clears
        bus_write(3'd0, 8'h00);
        bus_read(3'd0, rd);
        check(rd[7] == 1'b1, "R6 zero write", rd[7], 1);
        bus_write(3'd0, 8'h80);
        bus_read(3'd0, rd);
        check(rd[7] == 1'b0, "R6 clear", rd[7], 0);

        // R4 all rates back to back, no reset between
        for (int r = 0; r < 4; r++) begin
            period = 1 << (MIN_SHIFT + r);
            bus_write(3'd2, 8'(r));
            bus_read(3'd2, rd);
            check(rd == 8'(r), "R4 rate readback", rd, r);
            @(negedge clk);
            bus_write(3'd0, 8'h40);
            hit = -1;
            for (int k = 0; k < 3; k++) begin
                int t;
                t = 0;
                bus_read(3'd0, rd);
                while (!rd[6] && t < 200) begin
                    @(negedge clk);
                    bus_read(3'd0, rd);
                    t++;
                end
                if (hit < 0)
                    check(rd[6] && (cyc % period) == 0, "R4 tick on multiple", cyc % period, 0);
                else
                    check(rd[6] && (cyc - hit) == period, "R4 tick spacing", cyc - hit, period);
                hit = cyc;
                bus_write(3'd0, 8'h40);
            end
        end

        // R5 external strobes
        bus_write(3'd0, 8'hF0);
        pa_ovf_stb = 1'b1;
        @(posedge clk); @(negedge clk);
        pa_ovf_stb = 1'b0;
        bus_read(3'd0, rd);
        check(rd[5:4] == 2'b10, "R5 ovf strobe", rd[5:4], 2);
        pa_edge_stb = 1'b1;
        @(posedge clk); @(negedge clk);
        pa_edge_stb = 1'b0;
        bus_read(3'd0, rd);
        check(rd[5:4] == 2'b11, "R5 edge strobe", rd[5:4], 3);

        // R7 set and clear in the same cycle
        pa_edge_stb = 1'b1;
        bus_write(3'd0, 8'h10);
        pa_edge_stb = 1'b0;
        bus_read(3'd0, rd);
        check(rd[4] == 1'b1, "R7 set wins", rd[4], 1);
        bus_write(3'd0, 8'h10);
        bus_read(3'd0, rd);
        check(rd[5:4] == 2'b10, "R6 selective clear", rd[5:4], 2);

        // R8/R9 mask sweep against each combination of external flags
        for (int p = 0; p < 4; p++) begin
            bus_write(3'd0, 8'hF0);
            pa_ovf_stb = p[1];
            pa_edge_stb = p[0];
            @(posedge clk); @(negedge clk);
            pa_ovf_stb = 1'b0;
            pa_edge_stb = 1'b0;
            for (int m = 0; m < 16; m++) begin
                bus_write(3'd1, {m[3:0], 4'hF});
                bus_read(3'd1, rd);
                check(rd == {m[3:0], 4'h0}, "R8 mask readback", rd, {m[3:0], 4'h0});
                bus_read(3'd0, rd2);
                check(rd2[3:0] == 4'h0, "R8 flag low bits", rd2[3:0], 0);
                check(irq == |(rd2[7:4] & m[3:0]), "R9 irq", irq, |(rd2[7:4] & m[3:0]));
                if (m == 0 && p != 0)
                    check(rd2[5:4] == p[1:0], "R9 polling flags", rd2[5:4], p);
            end
        end
        bus_write(3'd2, 8'hFF);
        bus_read(3'd2, rd);
        check(rd == 8'h03, "R8 rate high bits", rd, 3);

        summary();
    end
endmodule